// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block watches a bank of general-purpose port pins and requests attention from a host whenever their levels move away from a stored reference copy. The pins arrive asynchronously. A chain of flip-flops brings them into the clock domain, and the synchronized value is compared against a snapshot register. While the two differ, the block asks for the shared interrupt line to be pulled low. The line is open drain, so several such blocks can share one wired-AND request wire.

The request is a level, not a latched event. If the pins go back to the values held in the snapshot, the request drops by itself. The host re-arms the block only through bus traffic. A read strobe from the bus interface takes a fresh snapshot on its rising edge. A write strobe takes one on both its rising and its falling edge. Any of these edges clears the request. A pin change that settles while a write strobe is still high is absorbed by the capture on the falling edge. A change that arrives after the clear raises a new request.

Top module: `port_chg_irq`

## Requirements
- R1: After a synchronous reset held for at least SYNC_STAGES+1 cycles with steady pins, int_pending is 0. The snapshot then equals the pins held during reset, so no request follows while the pins stay unchanged.
- R2: A rising or a falling transition on any single pin, or on several pins together, sets int_pending. This happens exactly SYNC_STAGES+1 clock edges after the pin change is first sampled (3 edges by default), and not earlier.
- R3: If the pins return to the snapshot values without any strobe, int_pending returns to 0 with the same SYNC_STAGES+1 edge latency.
- R4: The clock edge on which rd_stb is first seen at 1 (a 0-to-1 change of the sampled level) clears int_pending and loads the snapshot with the synchronized pins. While rd_stb stays at 1 nothing more is captured, and its return to 0 does nothing.
- R5: wr_stb clears int_pending and loads the snapshot both on the edge where it is first seen at 1 and on the edge where it is first seen at 0. A pin change that settles while wr_stb is high can raise a request, and the falling-edge capture absorbs that change.
- R6: Once a clear has taken place, any later pin change raises a new request.
- R7: int_drive_low, the enable of the open-drain pull-down (1 = pull the shared line low), equals int_pending on every cycle.
- R8: A difference between the synchronized pins and the snapshot never stays unreported for LAT_BOUND_CYC cycles or more. At 50 MHz this bound is 4 µs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | PIN_W | Asynchronous port pin levels |
| rd_stb | input | 1 | Read pulse from the bus interface |
| wr_stb | input | 1 | Write pulse from the bus interface |
| int_drive_low | output | 1 | Enable of the open-drain low driver on the shared interrupt line |
| int_pending | output | 1 | Status flag, 1 while a change is being reported |

## Verification
The checker watches every cycle for four things. A difference between synchronized pins and snapshot must raise the request on the next edge, and a match must drop it. Every strobe edge must clear the request and reload the snapshot from the synchronized pins. The snapshot must hold between captures. The latency counter must stay under the bound. The bench scenarios show what needs the raw pins and the strobe waveforms together:
- the exact edge count from a pin change to the request on each of the eight pins, in both directions;
- that a held read strobe does not re-arm the block;
- that a change made inside a write pulse is absorbed at its falling edge;
- that a one-cycle pin glitch produces only a one-cycle request.

// File: rtl/pcig_pkg.sv
package pcig_pkg;

    // Strobe edges decoded from the bus interface pulses
    typedef struct packed {
        logic rd_rise;
        logic wr_rise;
        logic wr_fall;
    } strobe_ev_t;

    // Any decoded strobe edge takes a new snapshot and clears the request
    function automatic logic ev_capture(input strobe_ev_t ev);
        return ev.rd_rise | ev.wr_rise | ev.wr_fall;
    endfunction

endpackage

// File: rtl/pcig_sync.sv
module pcig_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    // No reset: the chain keeps sampling during reset so the snapshot can load live levels
    always_ff @(posedge clk) begin
        stage_q[0] <= din;
        for (int i = 1; i < STAGES; i++) begin
            stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pcig_strobe_edge.sv
module pcig_strobe_edge
    import pcig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_stb,
    input  logic       wr_stb,
    output strobe_ev_t ev
);
    logic rd_q, wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
        end else begin
            rd_q <= rd_stb;
            wr_q <= wr_stb;
        end
    end

    always_comb begin
        ev.rd_rise = rd_stb & ~rd_q;
        ev.wr_rise = wr_stb & ~wr_q;
        ev.wr_fall = ~wr_stb & wr_q;
    end
endmodule

// File: rtl/pcig_snap_cmp.sv
module pcig_snap_cmp
    import pcig_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins_sync,
    input  strobe_ev_t   ev,
    output logic [W-1:0] snap,
    output logic         pend
);
    logic cap;
    assign cap = ev_capture(ev);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= pins_sync;
            pend <= 1'b0;
        end else if (cap) begin
            snap <= pins_sync;
            pend <= 1'b0;
        end else begin
            pend <= (pins_sync != snap);
        end
    end
endmodule

// File: rtl/port_chg_irq.sv
module port_chg_irq
    import pcig_pkg::*;
#(
    parameter int PIN_W         = 8,
    parameter int SYNC_STAGES   = 2,
    parameter int LAT_BOUND_CYC = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] pin_i,
    input  logic             rd_stb,
    input  logic             wr_stb,
    output logic             int_drive_low,
    output logic             int_pending
);
    localparam int REPORT_LAT = SYNC_STAGES + 1;

    logic [PIN_W-1:0] pins_sync;
    logic [PIN_W-1:0] snap_q;
    strobe_ev_t       ev;
    logic             capture;
    logic             pend_q;

    pcig_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (pin_i),
        .dout (pins_sync)
    );

    pcig_strobe_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb),
        .ev     (ev)
    );

    pcig_snap_cmp #(.W(PIN_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .pins_sync (pins_sync),
        .ev        (ev),
        .snap      (snap_q),
        .pend      (pend_q)
    );

    assign capture       = ev_capture(ev);
    assign int_pending   = pend_q;
    assign int_drive_low = pend_q;

    // The worst-case report latency must fit inside the bound
    initial begin
        if (REPORT_LAT >= LAT_BOUND_CYC) begin
            $error("LAT_BOUND_CYC too small for SYNC_STAGES");
        end
    end
endmodule

// File: rtl/pcig_checker.sv
module pcig_checker #(
    parameter int W   = 8,
    parameter int LAT = 200
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] pins_sync,
    input logic [W-1:0] snap,
    input logic         cap,
    input logic         int_pending
);
    localparam int CW = $clog2(LAT + 2);

    logic [CW-1:0] lag_q;

    always_ff @(posedge clk) begin
        if (rst || int_pending || (pins_sync == snap)) begin
            lag_q <= '0;
        end else if (lag_q != '1) begin
            lag_q <= lag_q + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !int_pending); // R1

    AST_RAISE_ON_DIFF: assert property (@(posedge clk) disable iff (rst)
        (!cap && (pins_sync != snap)) |=> int_pending); // R2

    AST_DROP_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        (!cap && (pins_sync == snap)) |=> !int_pending); // R3

    AST_CLEAR_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        cap |=> !int_pending); // R4

    AST_SNAP_LOADS: assert property (@(posedge clk) disable iff (rst)
        cap |=> (snap == $past(pins_sync))); // R5

    AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(snap)); // R6

    AST_LAT_BOUND: assert property (@(posedge clk) disable iff (rst)
        lag_q < CW'(LAT)); // R8
endmodule

bind port_chg_irq pcig_checker #(.W(PIN_W), .LAT(LAT_BOUND_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pins_sync   (pins_sync),
    .snap        (snap_q),
    .cap         (capture),
    .int_pending (int_pending)
);

// File: tb/tb_port_chg_irq.sv
module tb_port_chg_irq;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] pins;
    logic         rd, wr;
    logic         int_drive_low, int_pending;

    always #10 clk = ~clk;   // 50 MHz

    port_chg_irq #(.PIN_W(W), .SYNC_STAGES(2), .LAT_BOUND_CYC(200)) dut (
        .clk           (clk),
        .rst           (rst),
        .pin_i         (pins),
        .rd_stb        (rd),
        .wr_stb        (wr),
        .int_drive_low (int_drive_low),
        .int_pending   (int_pending)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural reference: pin history queue, snapshot, expected request
    logic [W-1:0] hist [$];
    logic [W-1:0] snap_m;
    logic         irq_m   = 1'b0;
    logic         rd_prev = 1'b0;
    logic         wr_prev = 1'b0;

    always @(posedge clk) begin
        logic         cap;
        logic [W-1:0] seen;
        hist.push_back(pins);
        if (hist.size() > 3) void'(hist.pop_front());
        seen = hist[0];   // pins as sampled two edges earlier
        cap  = (rd && !rd_prev) || (wr != wr_prev);
        if (rst) begin
            snap_m  = seen;
            irq_m   = 1'b0;
            rd_prev = 1'b0;
            wr_prev = 1'b0;
        end else begin
            irq_m   = cap ? 1'b0 : (seen != snap_m);
            if (cap) snap_m = seen;
            rd_prev = rd;
            wr_prev = wr;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 R3 model", int_pending, irq_m);
            chk("R7 drive", int_drive_low, irq_m);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rd = 1'b0; wr = 1'b0; pins = 8'hA5;
        cyc(5);
        rst = 1'b0;
        cyc(1); chk("R1 idle after reset", int_pending, 1'b0);
        cyc(4); chk("R1 snapshot holds reset pins", int_pending, 1'b0);

        // R2 each pin, both directions, exact latency; R4 read clears; R6 re-raise
        for (int pass = 0; pass < 2; pass++) begin
            for (int b = 0; b < W; b++) begin
                pins[b] = ~pins[b];
                cyc(2); chk("R2 not before latency", int_pending, 1'b0);
                cyc(1); chk("R2 raised", int_pending, 1'b1);
                chk("R7 pull low", int_drive_low, 1'b1);
                rd = 1'b1;
                cyc(1); chk("R4 read clears", int_pending, 1'b0);
                rd = 1'b0;
                cyc(3); chk("R4 snapshot reloaded", int_pending, 1'b0);
            end
        end

        // R2 all pins together
        pins = ~pins;
        cyc(3); chk("R2 all pins", int_pending, 1'b1);
        rd = 1'b1; cyc(1); rd = 1'b0; cyc(1);

        // R3 return to snapshot without strobe
        pins = pins ^ 8'h0C;
        cyc(3); chk("R3 raised first", int_pending, 1'b1);
        pins = pins ^ 8'h0C;
        cyc(2); chk("R3 still up inside latency", int_pending, 1'b1);
        cyc(1); chk("R3 dropped by itself", int_pending, 1'b0);

        // R4 held read strobe does not re-arm
        rd = 1'b1;
        cyc(1); chk("R4 rise", int_pending, 1'b0);
        pins = pins ^ 8'h80;
        cyc(3); chk("R4 held high no capture", int_pending, 1'b1);
        rd = 1'b0;
        cyc(2); chk("R4 fall no effect", int_pending, 1'b1);
        rd = 1'b1;
        cyc(1); chk("R4 new rise clears", int_pending, 1'b0);
        rd = 1'b0;

        // R5 write strobe edges
        pins = pins ^ 8'h01;
        cyc(3); chk("R5 setup raised", int_pending, 1'b1);
        wr = 1'b1;
        cyc(1); chk("R5 write rise clears", int_pending, 1'b0);
        pins = pins ^ 8'h10;
        cyc(3); chk("R5 change during pulse", int_pending, 1'b1);
        wr = 1'b0;
        cyc(1); chk("R5 write fall clears", int_pending, 1'b0);
        cyc(4); chk("R5 change absorbed", int_pending, 1'b0);

        // R6 change after clear
        pins = pins ^ 8'h40;
        cyc(3); chk("R6 new request", int_pending, 1'b1);
        rd = 1'b1; cyc(1); rd = 1'b0; cyc(2);

        // One-cycle glitch: one-cycle request, then quiet
        pins = pins ^ 8'h02;
        cyc(1);
        pins = pins ^ 8'h02;
        cyc(2); chk("R2 glitch seen", int_pending, 1'b1);
        cyc(1); chk("R3 glitch gone", int_pending, 1'b0);
        cyc(3); chk("R3 stays quiet", int_pending, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule